// File: doc/BRIEF.md
# ADC Conversion Start Sequencer

This block is the digital control core of a successive-approximation converter. It starts a conversion when it sees either a rising edge on a hardware start strobe or a control-register write that sets the software start bit. The start is aligned to the master clock, and the block puts the track/hold into hold mode. It then counts out the conversion and raises a busy flag for its whole length. The length depends on whether the start met its setup margin to the aligning clock edge. This margin is modelled as a synchronous `setup_ok_i` input that is sampled in the same cycle as the start.

When the conversion ends, the block drops busy and returns the track/hold to track mode. It emits a one-cycle done pulse, publishes a new result word from a stub counter, and clears the software start bit. An acquisition window of a fixed number of cycles then follows. No start is accepted during that window or while busy is high. The `done_o` pulse and `result_o` are plain status and data: there is no handshake, and the word simply holds until the next conversion ends.

All registers use the rising edge of `clk`. The reset `rst_n` is asynchronous and active low.

Top module: `adc_start_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy_o`, `hold_o`, `done_o` and `start_bit_o` are 0 and `result_o` is 0. An assertion of reset during a conversion aborts it.
- R2: A rising edge of `conv_strobe_i` while idle is a start: it is 0 at one clock edge and 1 at the next. `busy_o` and `hold_o` are 1 from the cycle after the edge that samples the 1. A strobe held high starts only one conversion.
- R3: A write with `ctrl_wr_i`=1 and `ctrl_start_i`=1 while idle starts a conversion and sets `start_bit_o` to 1 from the next cycle. A write with `ctrl_start_i`=0 starts nothing and leaves `start_bit_o` at 0.
- R4: `busy_o` stays high for exactly CONV_CYC cycles when `setup_ok_i` was 1 at the accepting edge, and for CONV_CYC+1 cycles when it was 0.
- R5: In the first cycle with `busy_o` low after a conversion, `done_o` is 1 for that cycle only, and `hold_o` is 0 in the same cycle.
- R6: `start_bit_o` reads 0 from the cycle in which `busy_o` falls.
- R7: Strobe edges and start writes sampled while `busy_o` is high are ignored. They change neither the busy length nor `start_bit_o`.
- R8: After busy falls, starts sampled at the first ACQ_CYC-1 edges are ignored. A start sampled at the ACQ_CYC-th edge is accepted, so back-to-back conversions repeat every CONV_CYC+ACQ_CYC (or +1) cycles.
- R9: `result_o` has its upper WORD_W-RES_W bits at 0. Its lower RES_W bits hold the number of completed conversions since reset, modulo 2^RES_W, and update in the cycle `done_o` is 1.
- R10: A strobe edge and a start write in the same cycle start a single conversion, and `start_bit_o` reads 1 during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_strobe_i | input | 1 | Hardware conversion start strobe, starts on its rising edge |
| ctrl_wr_i | input | 1 | Control-register write strobe for the start bit |
| ctrl_start_i | input | 1 | Start bit value written with `ctrl_wr_i` |
| setup_ok_i | input | 1 | 1 when the start met the setup margin, sampled with the start |
| hold_o | output | 1 | 1 = track/hold in hold mode, 0 = track mode |
| busy_o | output | 1 | High for the duration of a conversion |
| done_o | output | 1 | One-cycle pulse when a conversion ends |
| start_bit_o | output | 1 | Readback of the software start bit |
| result_o | output | WORD_W | Result word: zero padding above a RES_W-bit stub value |

## Verification
The bench builds the block with its default parameters: CONV_CYC=20, ACQ_CYC=2, RES_W=14 and WORD_W=16. These values make the exact 20- and 21-cycle busy windows observable, along with the two-cycle acquisition gap in which the first retry is dropped and the second is taken. They also show the two zero padding bits above the 14-bit result. A vector table covers every start source with both setup outcomes. Directed cases cover starts during busy, a held strobe, a zero write and a reset in mid-conversion.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CONV = 2'd1,
    SEQ_ACQ  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adcseq_start_detect.sv
// Turns the strobe pin and register write into start requests and owns
// the self-clearing software start bit.
module adcseq_start_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic accept_i,
  input  logic clear_i,
  output logic pin_req_o,
  output logic sw_req_o,
  output logic sw_bit_o
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_i;
  end

  assign pin_req_o = strobe_i & ~strobe_q;
  assign sw_req_o  = wr_i & wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sw_bit_o <= 1'b0;
    else if (clear_i)              sw_bit_o <= 1'b0;
    else if (accept_i && sw_req_o) sw_bit_o <= 1'b1;
  end

  // R7: the bit moves only on an accepted start or on the end of conversion
  assert_swbit_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_i && !clear_i) |=> $stable(sw_bit_o));

  // R3: an accepted software write sets the bit
  assert_swbit_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && wr_i && wdata_i) |=> sw_bit_o);
endmodule

// File: rtl/adcseq_timer.sv
// Conversion and acquisition timing state machine.
module adcseq_timer
  import adcseq_pkg::*;
#(
  parameter int CONV_CYC = 20,
  parameter int ACQ_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic setup_ok_i,
  output logic accept_o,
  output logic end_o,
  output logic busy_o,
  output logic hold_o,
  output logic done_o
);
  localparam int CW = $clog2(CONV_CYC + 2);
  localparam int AW = (ACQ_CYC > 1) ? $clog2(ACQ_CYC) : 1;
  localparam int GW = $clog2(ACQ_CYC + 1);

  seq_state_t     state;
  logic [CW-1:0]  cnt;
  logic [AW-1:0]  acnt;
  logic           ready;

  assign ready    = (state == SEQ_IDLE) || ((state == SEQ_ACQ) && (acnt == '0));
  assign accept_o = ready && req_i;
  assign end_o    = (state == SEQ_CONV) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      cnt    <= '0;
      acnt   <= '0;
      busy_o <= 1'b0;
      hold_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        SEQ_CONV: begin
          if (cnt == '0) begin
            state  <= SEQ_ACQ;
            acnt   <= AW'(ACQ_CYC - 1);
            busy_o <= 1'b0;
            hold_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (accept_o) begin
            state  <= SEQ_CONV;
            cnt    <= setup_ok_i ? CW'(CONV_CYC - 1) : CW'(CONV_CYC);
            busy_o <= 1'b1;
            hold_o <= 1'b1;
          end else if (state == SEQ_ACQ) begin
            if (acnt == '0) state <= SEQ_IDLE;
            else            acnt  <= acnt - 1'b1;
          end
        end
      endcase
    end
  end

  // Checker state: busy length and gap since the last conversion
  logic [CW-1:0] chk_cnt;
  logic [CW-1:0] chk_exp;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_cnt <= '0;
      chk_exp <= '0;
      gap_cnt <= GW'(ACQ_CYC);
    end else begin
      chk_cnt <= busy_o ? chk_cnt + 1'b1 : '0;
      if (accept_o) chk_exp <= setup_ok_i ? CW'(CONV_CYC) : CW'(CONV_CYC + 1);
      if (end_o) gap_cnt <= '0;
      else if (!busy_o && gap_cnt < GW'(ACQ_CYC)) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R4: busy lasts the length chosen by the setup flag
  assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> (chk_cnt + CW'(1) == chk_exp));

  // R8: a new conversion never starts inside the acquisition window
  assert_acq_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (gap_cnt >= GW'(ACQ_CYC)));

  // R2: busy only rises after a request
  assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_i));

  // R5: done is a single-cycle pulse
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: busy falls together with done and the return to track mode
  assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o && !hold_o));
endmodule

// File: rtl/adcseq_result_stub.sv
// Stand-in for the converter data path: counts completed conversions.
module adcseq_result_stub #(
  parameter int RES_W  = 14,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              end_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int PAD = WORD_W - RES_W;

  logic [RES_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (end_i) cnt <= cnt + 1'b1;
  end

  generate
    if (PAD > 0) begin : g_pad
      assign word_o = {{PAD{1'b0}}, cnt};
    end else begin : g_nopad
      assign word_o = cnt[WORD_W-1:0];
    end
  endgenerate

  // R9: one step per completed conversion, otherwise unchanged
  assert_res_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    end_i |=> (cnt == $past(cnt) + 1'b1));
  assert_res_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !end_i |=> $stable(cnt));
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq #(
  parameter int CONV_CYC = 20,
  parameter int ACQ_CYC  = 2,
  parameter int RES_W    = 14,
  parameter int WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_strobe_i,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_start_i,
  input  logic              setup_ok_i,
  output logic              hold_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              start_bit_o,
  output logic [WORD_W-1:0] result_o
);
  logic pin_req, sw_req, accept, conv_end;

  adcseq_start_detect u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (conv_strobe_i),
    .wr_i     (ctrl_wr_i),
    .wdata_i  (ctrl_start_i),
    .accept_i (accept),
    .clear_i  (conv_end),
    .pin_req_o(pin_req),
    .sw_req_o (sw_req),
    .sw_bit_o (start_bit_o)
  );

  adcseq_timer #(
    .CONV_CYC(CONV_CYC),
    .ACQ_CYC (ACQ_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (pin_req | sw_req),
    .setup_ok_i(setup_ok_i),
    .accept_o  (accept),
    .end_o     (conv_end),
    .busy_o    (busy_o),
    .hold_o    (hold_o),
    .done_o    (done_o)
  );

  adcseq_result_stub #(
    .RES_W (RES_W),
    .WORD_W(WORD_W)
  ) u_result (
    .clk   (clk),
    .rst_n (rst_n),
    .end_i (conv_end),
    .word_o(result_o)
  );

  // R6: the software bit is already clear when busy is seen low
  assert_bit_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !start_bit_o);

  // R9: the result word changes only together with done
  assert_result_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
endmodule

// File: tb/adc_start_seq_tb_top.sv
module adc_start_seq_tb_top;
  localparam int CONV = 20;
  localparam int ACQ  = 2;
  localparam int WW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_strobe = 1'b0, ctrl_wr = 1'b0, ctrl_start = 1'b0, setup_ok = 1'b0;
  logic hold_o, busy_o, done_o, start_bit_o;
  logic [WW-1:0] result_o;

  int checks = 0;
  int errors = 0;
  int nconv  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_start_seq #(.CONV_CYC(CONV), .ACQ_CYC(ACQ), .RES_W(14), .WORD_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_strobe_i(conv_strobe), .ctrl_wr_i(ctrl_wr),
    .ctrl_start_i(ctrl_start), .setup_ok_i(setup_ok), .hold_o(hold_o),
    .busy_o(busy_o), .done_o(done_o), .start_bit_o(start_bit_o), .result_o(result_o)
  );

  // Vector: [2:1] source (1 pin, 2 software write, 3 both), [0] setup flag
  localparam logic [2:0] VEC [8] = '{3'b011, 3'b010, 3'b101, 3'b100,
                                     3'b111, 3'b110, 3'b010, 3'b101};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] kind, input logic su);
    conv_strobe = kind[0];
    ctrl_wr     = kind[1];
    ctrl_start  = kind[1];
    setup_ok    = su;
    @(negedge clk);
    conv_strobe = 1'b0;
    ctrl_wr     = 1'b0;
    ctrl_start  = 1'b0;
  endtask

  task automatic measure(output int len);
    len = 0;
    while (busy_o && len < 100) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic check_end(input string tag);
    nconv++;
    chk(done_o == 1'b1, {tag, " R5 done"}, int'(done_o), 1);
    chk(hold_o == 1'b0, {tag, " R5 hold"}, int'(hold_o), 0);
    chk(start_bit_o == 1'b0, {tag, " R6 start bit"}, int'(start_bit_o), 0);
    chk(result_o == WW'(nconv), {tag, " R9 result"}, int'(result_o), nconv);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0 && hold_o == 1'b0, "R1 reset busy/hold", int'({busy_o, hold_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy_o, hold_o, done_o, start_bit_o} == 4'b0, "R1 after reset flags",
        int'({busy_o, hold_o, done_o, start_bit_o}), 0);
    chk(result_o == '0, "R1 after reset result", int'(result_o), 0);

    // Vector table: every source with both setup outcomes
    for (int i = 0; i < 8; i++) begin
      logic [1:0] kind;
      kind = VEC[i][2:1];
      do_start(kind, VEC[i][0]);
      chk(busy_o && hold_o, "R2 R3 start busy/hold", int'({busy_o, hold_o}), 3);
      chk(start_bit_o == kind[1], "R3 R10 start bit readback", int'(start_bit_o), int'(kind[1]));
      measure(len);
      chk(len == (VEC[i][0] ? CONV : CONV + 1), "R4 busy length", len,
          VEC[i][0] ? CONV : CONV + 1);
      check_end("vec");
      @(negedge clk);
      chk(done_o == 1'b0, "R5 done width", int'(done_o), 0);
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b0, "R10 single conversion", int'(busy_o), 0);
    end

    // R7: starts during busy are ignored
    do_start(2'b01, 1'b1);
    len = 1;
    while (busy_o && len < 100) begin
      if (len == 5) begin conv_strobe = 1'b1; ctrl_wr = 1'b1; ctrl_start = 1'b1; end
      if (len == 6) begin
        conv_strobe = 1'b0; ctrl_wr = 1'b0; ctrl_start = 1'b0;
        chk(start_bit_o == 1'b0, "R7 write during busy", int'(start_bit_o), 0);
      end
      @(negedge clk);
      if (busy_o) len++;
    end
    chk(len == CONV, "R7 busy length unchanged", len, CONV);
    check_end("busy-ignore");
    repeat (4) @(negedge clk);

    // R8: acquisition window
    do_start(2'b10, 1'b0);
    measure(len);
    chk(len == CONV + 1, "R8 first length", len, CONV + 1);
    check_end("acq");
    do_start(2'b10, 1'b1);
    chk(busy_o == 1'b0 && start_bit_o == 1'b0, "R8 start inside window ignored",
        int'({busy_o, start_bit_o}), 0);
    do_start(2'b10, 1'b1);
    chk(busy_o == 1'b1, "R8 start at window end accepted", int'(busy_o), 1);
    measure(len);
    chk(len == CONV, "R8 second length", len, CONV);
    check_end("acq2");
    repeat (4) @(negedge clk);

    // R2: a held strobe starts once
    conv_strobe = 1'b1;
    setup_ok = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b1, "R2 held strobe start", int'(busy_o), 1);
    measure(len);
    check_end("held");
    repeat (6) @(negedge clk);
    chk(busy_o == 1'b0, "R2 held strobe no restart", int'(busy_o), 0);
    conv_strobe = 1'b0;
    repeat (2) @(negedge clk);

    // R3: writing zero starts nothing
    ctrl_wr = 1'b1;
    ctrl_start = 1'b0;
    @(negedge clk);
    ctrl_wr = 1'b0;
    chk(busy_o == 1'b0 && start_bit_o == 1'b0, "R3 zero write", int'({busy_o, start_bit_o}), 0);
    repeat (2) @(negedge clk);

    // R1: reset in mid-conversion
    do_start(2'b10, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({busy_o, hold_o, done_o, start_bit_o} == 4'b0, "R1 reset abort flags",
        int'({busy_o, hold_o, done_o, start_bit_o}), 0);
    chk(result_o == '0, "R1 reset abort result", int'(result_o), 0);
    rst_n = 1'b1;
    nconv = 0;
    repeat (2) @(negedge clk);
    do_start(2'b01, 1'b0);
    measure(len);
    chk(len == CONV + 1, "R4 after reset length", len, CONV + 1);
    check_end("post-reset");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule